// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge and Vector Unit

This block holds the request and in-service state of two eight-line interrupt controllers arranged as a master and a slave. A request pending on the slave is passed to the master through the master's cascade line (line 2). The block tells the processor that an interrupt is pending. When the processor sends an acknowledge strobe, the block picks the winning line and updates both controllers' request and in-service state. One cycle later it returns the 8-bit vector, qualified by a one-cycle valid flag.

Each controller has its own settings: trigger mode per line, mask, vector base, automatic end-of-interrupt and rotation on automatic end-of-interrupt. The block has no command port. In-service bits are cleared only by reset, or are never set when automatic end-of-interrupt is enabled. An acknowledge that finds no winner returns a spurious vector.

Top module: `casc_ack_vector`

## Requirements
- R1: An edge-mode line sets its request bit on a rising input. A line that stays high does not raise a new request after its acknowledge. An acknowledge clears the request bit of an edge-mode line.
- R2: For a level-mode line (trigger bit 1), the request bit follows the input level one cycle later, and an acknowledge leaves it unchanged.
- R3: Among unmasked requests (mask bit 1 = masked), the winner is the line L with the smallest (L - offset) mod 8. The offset resets to 0.
- R4: A request is forwarded only if it ranks strictly ahead of every in-service line of the same controller. This lets higher lines nest and holds back lower lines.
- R5: With automatic end-of-interrupt off, an acknowledge sets the in-service bit of the acknowledged line.
- R6: With automatic end-of-interrupt on, an acknowledge leaves the in-service state unchanged.
- R7: With automatic end-of-interrupt and rotation both on, an acknowledge of line L sets that controller's offset to (L + 1) mod 8.
- R8: A slave request is forwarded to master line 2 and stays pending there until acknowledged. When master line 2 wins, the slave line is acknowledged and the vector is the slave base with the slave line in bits 2:0.
- R9: If master line 2 wins while the slave has no forwardable request, the vector is the slave base with 7 in bits 2:0, and the slave state does not change.
- R10: An acknowledge with no forwardable master request returns the master base with 7 in bits 2:0.
- R11: The vector takes bits 7:3 from the base input and ignores bits 2:0 of the base.
- R12: `int_o` is low in the cycle after an acknowledge. In every other cycle it shows, one cycle late, whether the master has a forwardable request. It is 0 during reset.
- R13: `vec_vld_o` is high for exactly the one cycle after each acknowledge. `vec_o` holds its value until the next acknowledge and resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_master_i | input | 8 | Master request lines (line 2 ignored, cascade) |
| irq_slave_i | input | 8 | Slave request lines |
| level_master_i | input | 8 | Master trigger mode per line, 1 = level (line 2 ignored) |
| level_slave_i | input | 8 | Slave trigger mode per line, 1 = level |
| mask_master_i | input | 8 | Master mask, 1 = masked |
| mask_slave_i | input | 8 | Slave mask, 1 = masked |
| aeoi_master_i | input | 1 | Master automatic end-of-interrupt |
| aeoi_slave_i | input | 1 | Slave automatic end-of-interrupt |
| rot_master_i | input | 1 | Master rotation on automatic end-of-interrupt |
| rot_slave_i | input | 1 | Slave rotation on automatic end-of-interrupt |
| base_master_i | input | 8 | Master vector base (bits 7:3 used) |
| base_slave_i | input | 8 | Slave vector base (bits 7:3 used) |
| ack_i | input | 1 | Acknowledge strobe, one cycle |
| int_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector of the last acknowledge |
| vec_vld_o | output | 1 | Vector valid, one cycle |

## Verification
The acknowledge path is exercised with five patterns:
- an acknowledge with nothing pending, which exposes the spurious master vector and the dropped base bits;
- held edge lines, which separate edge capture from level following;
- nested master lines, which show whether in-service state blocks lower lines and admits higher ones;
- two level lines under rotating automatic end-of-interrupt, with and without a mask, which show whether the offset moves to the line after the acknowledged one;
- a slave edge request and a withdrawn slave level request, which distinguish the cascaded vector from the spurious slave vector.

A behavioural model in the bench is compared with the outputs on every clock.

// File: rtl/casc_ack_pkg.sv
package casc_ack_pkg;
  typedef enum logic [1:0] {
    VSRC_MASTER = 2'd0,
    VSRC_SLAVE  = 2'd1,
    VSRC_SPUR_M = 2'd2,
    VSRC_SPUR_S = 2'd3
  } vec_src_e;
endpackage

// File: rtl/casc_req_capture.sv
module casc_req_capture #(
  parameter int LINES = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] lvl_i,
  input  logic [LINES-1:0] trig_i,
  input  logic [LINES-1:0] force_i,
  input  logic [LINES-1:0] clr_i,
  output logic [LINES-1:0] irr_o
);
  logic [LINES-1:0] irr_q, irr_d, last_q;
  logic             armed_q;

  always_comb begin
    for (int i = 0; i < LINES; i++) begin
      if (trig_i[i]) irr_d[i] = lvl_i[i];
      else           irr_d[i] = (irr_q[i] & ~clr_i[i]) | (lvl_i[i] & ~last_q[i]) | force_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q   <= '0;
      last_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      irr_q   <= irr_d;
      last_q  <= lvl_i;
      armed_q <= 1'b1;
    end
  end

  assign irr_o = irr_q;

  for (genvar g = 0; g < LINES; g++) begin : g_chk
    assert_edge_src_R1: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
      (!$past(trig_i[g]) && irr_q[g] && !$past(irr_q[g])) |-> ($past(lvl_i[g]) || $past(force_i[g])));
    assert_level_copy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
      $past(trig_i[g]) |-> (irr_q[g] == $past(lvl_i[g])));
  end
endmodule

// File: rtl/casc_resolver.sv
module casc_resolver #(
  parameter int LINES = 8,
  localparam int LW = $clog2(LINES),
  localparam int RW = LW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] irr_i,
  input  logic [LINES-1:0] mask_i,
  input  logic [LINES-1:0] isr_i,
  input  logic [LW-1:0]    off_i,
  output logic             vld_o,
  output logic [LW-1:0]    line_o
);
  logic [LINES-1:0] req;
  logic [RW-1:0]    req_rank, isr_rank;
  logic             req_hit, isr_hit;
  logic [LW-1:0]    idx;

  always_comb begin
    req      = irr_i & ~mask_i;
    req_hit  = 1'b0;
    isr_hit  = 1'b0;
    req_rank = RW'(LINES);
    isr_rank = RW'(LINES);
    line_o   = '0;
    idx      = '0;
    for (int r = 0; r < LINES; r++) begin
      idx = off_i + r[LW-1:0];
      if (!req_hit && req[idx]) begin
        req_hit  = 1'b1;
        req_rank = RW'(r);
        line_o   = idx;
      end
      if (!isr_hit && isr_i[idx]) begin
        isr_hit  = 1'b1;
        isr_rank = RW'(r);
      end
    end
    vld_o = req_hit && (req_rank < isr_rank);
  end

  assert_win_unmasked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> (irr_i[line_o] && !mask_i[line_o]));
  assert_win_not_serviced_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> !isr_i[line_o]);
endmodule

// File: rtl/casc_unit.sv
module casc_unit #(
  parameter int LINES = 8,
  localparam int LW = $clog2(LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] lvl_i,
  input  logic [LINES-1:0] trig_i,
  input  logic [LINES-1:0] mask_i,
  input  logic [LINES-1:0] force_i,
  input  logic             aeoi_i,
  input  logic             rot_i,
  input  logic             ack_i,
  output logic             vld_o,
  output logic [LW-1:0]    line_o
);
  logic [LINES-1:0] irr, isr_q, isr_d, clr, hit;
  logic [LW-1:0]    off_q, off_d;
  logic             isr_en, off_en;

  casc_req_capture #(.LINES(LINES)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (lvl_i),
    .trig_i (trig_i),
    .force_i(force_i),
    .clr_i  (clr),
    .irr_o  (irr)
  );

  casc_resolver #(.LINES(LINES)) u_res (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .irr_i (irr),
    .mask_i(mask_i),
    .isr_i (isr_q),
    .off_i (off_q),
    .vld_o (vld_o),
    .line_o(line_o)
  );

  always_comb begin
    hit    = '0;
    hit[line_o] = 1'b1;
    clr    = ack_i ? (hit & ~trig_i) : '0;
    isr_en = ack_i && !aeoi_i;
    off_en = ack_i && aeoi_i && rot_i;
    isr_d  = isr_q | hit;
    off_d  = line_o + LW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q <= '0;
      off_q <= '0;
    end else begin
      if (isr_en) isr_q <= isr_d;
      if (off_en) off_q <= off_d;
    end
  end

  assert_ack_has_winner_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |-> vld_o);
  assert_isr_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !aeoi_i) |=> isr_q[$past(line_o)]);
  assert_aeoi_no_isr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && aeoi_i) |=> $stable(isr_q));
  assert_rotate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && aeoi_i && rot_i) |=> (off_q == LW'($past(line_o) + LW'(1))));
endmodule

// File: rtl/casc_ack_vector.sv
module casc_ack_vector
  import casc_ack_pkg::*;
#(
  parameter int LINES     = 8,
  parameter int VEC_W     = 8,
  parameter int CASC_LINE = 2,
  localparam int LW = $clog2(LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] irq_master_i,
  input  logic [LINES-1:0] irq_slave_i,
  input  logic [LINES-1:0] level_master_i,
  input  logic [LINES-1:0] level_slave_i,
  input  logic [LINES-1:0] mask_master_i,
  input  logic [LINES-1:0] mask_slave_i,
  input  logic             aeoi_master_i,
  input  logic             aeoi_slave_i,
  input  logic             rot_master_i,
  input  logic             rot_slave_i,
  input  logic [VEC_W-1:0] base_master_i,
  input  logic [VEC_W-1:0] base_slave_i,
  input  logic             ack_i,
  output logic             int_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             vec_vld_o
);
  localparam logic [LINES-1:0] CASC_BIT = LINES'(1) << CASC_LINE;
  localparam logic [LW-1:0]    CASC_IDX = LW'(CASC_LINE);
  localparam logic [LW-1:0]    SPUR_IDX = LW'(LINES - 1);
  localparam logic [VEC_W-1:0] HI_MASK  = ~VEC_W'(LINES - 1);

  logic [LINES-1:0] m_lvl, m_trig, m_force, s_force;
  logic             m_vld, s_vld, m_ack, s_ack;
  logic [LW-1:0]    m_line, s_line;
  vec_src_e         src;
  logic [VEC_W-1:0] vec_d, vec_q;
  logic             int_d, int_q, vld_q;

  always_comb begin
    m_lvl   = irq_master_i & ~CASC_BIT;
    m_trig  = level_master_i & ~CASC_BIT;
    m_force = (s_vld && !ack_i) ? CASC_BIT : '0;
    s_force = '0;
    m_ack   = ack_i && m_vld;
    s_ack   = m_ack && (m_line == CASC_IDX) && s_vld;
  end

  casc_unit #(.LINES(LINES)) u_master (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (m_lvl),
    .trig_i (m_trig),
    .mask_i (mask_master_i),
    .force_i(m_force),
    .aeoi_i (aeoi_master_i),
    .rot_i  (rot_master_i),
    .ack_i  (m_ack),
    .vld_o  (m_vld),
    .line_o (m_line)
  );

  casc_unit #(.LINES(LINES)) u_slave (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (irq_slave_i),
    .trig_i (level_slave_i),
    .mask_i (mask_slave_i),
    .force_i(s_force),
    .aeoi_i (aeoi_slave_i),
    .rot_i  (rot_slave_i),
    .ack_i  (s_ack),
    .vld_o  (s_vld),
    .line_o (s_line)
  );

  always_comb begin
    if (!m_vld)                  src = VSRC_SPUR_M;
    else if (m_line != CASC_IDX) src = VSRC_MASTER;
    else if (s_vld)              src = VSRC_SLAVE;
    else                         src = VSRC_SPUR_S;
    unique case (src)
      VSRC_MASTER: vec_d = (base_master_i & HI_MASK) | VEC_W'(m_line);
      VSRC_SLAVE:  vec_d = (base_slave_i  & HI_MASK) | VEC_W'(s_line);
      VSRC_SPUR_S: vec_d = (base_slave_i  & HI_MASK) | VEC_W'(SPUR_IDX);
      default:     vec_d = (base_master_i & HI_MASK) | VEC_W'(SPUR_IDX);
    endcase
    int_d = m_vld && !ack_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_q <= '0;
      vld_q <= 1'b0;
      int_q <= 1'b0;
    end else begin
      if (ack_i) vec_q <= vec_d;
      vld_q <= ack_i;
      int_q <= int_d;
    end
  end

  assign vec_o     = vec_q;
  assign vec_vld_o = vld_q;
  assign int_o     = int_q;

  assert_vld_after_ack_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> vec_vld_o);
  assert_vld_single_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_i |=> !vec_vld_o);
  assert_int_low_after_ack_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> !int_o);
  assert_spur_master_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !m_vld) |=> (vec_o[LW-1:0] == SPUR_IDX));
  assert_base_hi_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !m_vld) |=> (vec_o[VEC_W-1:LW] == $past(base_master_i[VEC_W-1:LW])));
  assert_slave_line_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_ack |=> (vec_o[LW-1:0] == $past(s_line)));
  assert_spur_slave_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_ack && m_line == CASC_IDX && !s_vld) |=> (vec_o[LW-1:0] == SPUR_IDX));
endmodule

// File: tb/test_casc_ack_vector.sv
`timescale 1ns/1ps
module test_casc_ack_vector;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] irq_m, irq_s, lvl_m, lvl_s, msk_m, msk_s, bm, bs;
  logic       ae_m, ae_s, ro_m, ro_s, ack;
  logic       int_o, vec_vld;
  logic [7:0] vec;

  int total = 0;
  int bad = 0;
  string cur_tag = "R12";

  logic [7:0] m_irr [2];
  logic [7:0] m_isr [2];
  logic [7:0] m_last[2];
  int         m_off [2];
  logic [7:0] m_clr [2];
  logic       e_int, e_vld;
  logic [7:0] e_vec;

  always #4 clk = ~clk;

  casc_ack_vector i_casc_ack_vector (
    .clk_i(clk), .rst_ni(rst_n),
    .irq_master_i(irq_m), .irq_slave_i(irq_s),
    .level_master_i(lvl_m), .level_slave_i(lvl_s),
    .mask_master_i(msk_m), .mask_slave_i(msk_s),
    .aeoi_master_i(ae_m), .aeoi_slave_i(ae_s),
    .rot_master_i(ro_m), .rot_slave_i(ro_s),
    .base_master_i(bm), .base_slave_i(bs),
    .ack_i(ack), .int_o(int_o), .vec_o(vec), .vec_vld_o(vec_vld)
  );

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int resolve(logic [7:0] irr, logic [7:0] msk, logic [7:0] isr, int off);
    int rq = -1, rr = 8, ir = 8;
    for (int r = 0; r < 8; r++) begin
      int l = (off + r) % 8;
      if (rq < 0 && irr[l] && !msk[l]) begin rq = l; rr = r; end
      if (ir == 8 && isr[l]) ir = r;
    end
    return (rq >= 0 && rr < ir) ? rq : -1;
  endfunction

  task automatic model_ack(input int u, input int l, input bit aeoi, input bit rot, input logic [7:0] trig);
    if (aeoi) begin
      if (rot) m_off[u] = (l + 1) % 8;
    end else begin
      m_isr[u][l] = 1'b1;
    end
    if (!trig[l]) m_clr[u][l] = 1'b1;
  endtask

  task automatic model_reset();
    for (int u = 0; u < 2; u++) begin
      m_irr[u] = '0; m_isr[u] = '0; m_last[u] = '0; m_off[u] = 0;
    end
    e_int = 0; e_vld = 0; e_vec = '0;
  endtask

  task automatic compare();
    chk(int_o === e_int, cur_tag, "int_o", int_o, e_int);
    chk(vec_vld === e_vld, cur_tag, "vec_vld_o", vec_vld, e_vld);
    chk(vec === e_vec, cur_tag, "vec_o", vec, e_vec);
  endtask

  task automatic tick();
    logic [7:0] lv[2], tg[2], fc[2];
    int s, mw;
    logic [7:0] v;
    lv[0] = irq_m; lv[0][2] = 1'b0; tg[0] = lvl_m; tg[0][2] = 1'b0;
    lv[1] = irq_s; tg[1] = lvl_s;
    m_clr[0] = '0; m_clr[1] = '0;
    s  = resolve(m_irr[1], msk_s, m_isr[1], m_off[1]);
    mw = resolve(m_irr[0], msk_m, m_isr[0], m_off[0]);
    v = {bm[7:3], 3'd7};
    if (ack && mw >= 0) begin
      model_ack(0, mw, ae_m, ro_m, tg[0]);
      if (mw == 2) begin
        if (s >= 0) begin
          model_ack(1, s, ae_s, ro_s, tg[1]);
          v = {bs[7:3], 3'(s)};
        end else v = {bs[7:3], 3'd7};
      end else v = {bm[7:3], 3'(mw)};
    end
    fc[0] = '0; fc[1] = '0;
    fc[0][2] = (s >= 0) && !ack;
    for (int u = 0; u < 2; u++) begin
      for (int i = 0; i < 8; i++) begin
        if (tg[u][i]) m_irr[u][i] = lv[u][i];
        else m_irr[u][i] = (m_irr[u][i] & !m_clr[u][i]) | (lv[u][i] & !m_last[u][i]) | fc[u][i];
      end
      m_last[u] = lv[u];
    end
    e_int = ack ? 1'b0 : (mw >= 0);
    e_vld = ack;
    if (ack) e_vec = v;
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic do_ack(input logic [7:0] exp_vec, input string tag);
    ack = 1'b1;
    tick();
    ack = 1'b0;
    chk(vec_vld === 1'b1, tag, "vld after ack", vec_vld, 1);
    chk(vec === exp_vec, tag, "hand vector", vec, exp_vec);
    chk(int_o === 1'b0, "R12", "int after ack", int_o, 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    irq_m = '0; irq_s = '0; lvl_m = '0; lvl_s = '0; msk_m = '0; msk_s = '0;
    ae_m = 0; ae_s = 0; ro_m = 0; ro_s = 0; ack = 0;
    model_reset();
    @(negedge clk); @(negedge clk);
    chk(int_o === 1'b0 && vec_vld === 1'b0 && vec === 8'h00, "R12", "reset outputs", {int_o, vec_vld, vec}, 0);
    rst_n = 1'b1;
  endtask

  initial begin
    #1_000_000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bm = 8'h21; bs = 8'h70;
    do_reset();
    ticks(2);

    cur_tag = "R10";
    do_ack(8'h27, "R10");
    cur_tag = "R11";
    bm = 8'h2E;
    do_ack(8'h2F, "R11");
    bm = 8'h21;
    ticks(1);

    cur_tag = "R1";
    irq_m[3] = 1'b1;
    ticks(2);
    chk(int_o === 1'b1, "R1", "edge raises int", int_o, 1);
    do_ack(8'h23, "R5");
    ticks(3);
    chk(int_o === 1'b0, "R1", "held edge no re-request", int_o, 0);
    cur_tag = "R4";
    irq_m[1] = 1'b1;
    ticks(2);
    chk(int_o === 1'b1, "R4", "higher line nests", int_o, 1);
    do_ack(8'h21, "R4");
    irq_m[5] = 1'b1;
    ticks(4);
    chk(int_o === 1'b0, "R4", "lower line held back", int_o, 0);

    do_reset();
    cur_tag = "R6";
    lvl_m[4] = 1'b1; ae_m = 1'b1; irq_m[4] = 1'b1;
    ticks(3);
    do_ack(8'h24, "R2");
    ticks(1);
    chk(int_o === 1'b1, "R6", "level line back without in-service", int_o, 1);
    irq_m[4] = 1'b0;
    ticks(2);
    chk(int_o === 1'b0, "R2", "level drop withdraws", int_o, 0);

    do_reset();
    cur_tag = "R7";
    ae_m = 1'b1; ro_m = 1'b1; lvl_m = 8'h41; irq_m = 8'h41;
    ticks(3);
    do_ack(8'h20, "R3");
    ticks(2);
    do_ack(8'h26, "R7");
    ticks(2);
    do_ack(8'h20, "R7");
    ticks(2);
    cur_tag = "R3";
    msk_m = 8'h01;
    ticks(1);
    do_ack(8'h26, "R3");
    ticks(2);

    do_reset();
    cur_tag = "R8";
    irq_s[5] = 1'b1;
    ticks(4);
    chk(int_o === 1'b1, "R8", "slave forwarded", int_o, 1);
    do_ack(8'h75, "R8");
    ticks(3);
    chk(int_o === 1'b0, "R8", "no repeat after slave ack", int_o, 0);

    do_reset();
    cur_tag = "R9";
    lvl_s[1] = 1'b1; irq_s[1] = 1'b1;
    ticks(4);
    irq_s[1] = 1'b0;
    ticks(3);
    chk(int_o === 1'b1, "R9", "cascade request stays", int_o, 1);
    do_ack(8'h77, "R9");
    ticks(2);
    cur_tag = "R13";
    chk(vec_vld === 1'b0 && vec === 8'h77, "R13", "vector held, valid gone", {vec_vld, vec}, 8'h77);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule